// File: doc/BRIEF.md
# UART Receive Buffer with Automatic Hardware Handshake

This block sits between the serial shifters of a UART and its modem handshake pins and runs request-to-send / clear-to-send flow control without software. Received characters, each with three error flags, enter a receive buffer. Software selects a depth of 16 or 64 entries, or a single-entry holding register when buffered operation is off. When automatic RTS is enabled in buffered mode, the active-low `rts_n` output is released (driven high) once the buffer reaches a selected fill level. It is driven low again only after the buffer has been drained to empty. This holds off the remote sender before the buffer overflows.

On the transmit side the active-low `cts_n` input passes through a two-stage synchroniser. When automatic CTS is enabled in buffered mode, `tx_start_ok` tells the transmit shifter whether it may begin a new character. A character that has already started always finishes. When a CTS deassertion arrives, the stall takes hold at the next character boundary. When neither automatic function is active, `rts_n` simply mirrors the software request and CTS gates nothing.

Two state machines carry the control. The RTS machine has three states. `RTS_SOFT` means the pin follows software. `RTS_OPEN` means the pin is asserted and the buffer is filling. `RTS_HELD` means the pin is released and the machine waits for empty. Its transitions are: SOFT→OPEN when automatic RTS becomes active; OPEN→HELD when the count reaches the trigger level; HELD→OPEN when the buffer is empty; any→SOFT when automatic RTS drops or a configuration flush occurs. The transmit gate machine also has three states. `TXG_IDLE` is a character boundary, `TXG_BUSY` is a character in flight, and `TXG_HOLD` is stalled by CTS. Its transitions are: IDLE→BUSY on `tx_start` while allowed; BUSY→IDLE on `tx_end`; IDLE→HOLD when gating is active and the synchronised CTS is inactive; HOLD→IDLE when CTS returns or gating drops.

Top module: `uart_afc`

## Requirements
- R1: After reset the buffer is empty (`rx_count`=0, `rx_empty`=1). With automatic RTS and CTS inactive, `rts_n` equals the inverse of `sw_rts` and `tx_start_ok` is 1.
- R2: Entries leave in arrival order. Each entry carries the 8-bit character and its 3 error bits: bit 0 parity, bit 1 framing, bit 2 break.
- R3: Capacity is 16 entries when `fifo_en`=1 and `depth64`=0, 64 entries when `fifo_en`=1 and `depth64`=1, and 1 entry when `fifo_en`=0. A push into a full buffer, without a pop in the same cycle, is dropped. A pop from an empty buffer is ignored.
- R4: The trigger level for depth D is 1, D/4, D/2 or D−D/8 for `trig_sel` 0, 1, 2 or 3. With `fifo_en`=1 and `auto_rts_en`=1, `rts_n` goes high on the clock edge after the one on which `rx_count` reaches the trigger level.
- R5: Once released by R4, `rts_n` stays high while the buffer holds any entry, even below the trigger level. It returns low on the clock edge after the buffer becomes empty.
- R6: When `fifo_en`=0 or `auto_rts_en`=0, `rts_n` equals the inverse of `sw_rts` from the next clock edge on.
- R7: A change of `depth64` or `fifo_en` empties the buffer on the next clock edge. During the cycle that follows that edge, `rts_n` shows the software value.
- R8: With `fifo_en`=1 and `auto_cts_en`=1 at a character boundary, raising `cts_n` drops `tx_start_ok` after exactly two clock edges. Lowering `cts_n` raises it again after three edges.
- R9: Between `tx_start` and `tx_end`, `tx_start_ok` is 0 and a CTS change does not end the character. If CTS is inactive when `tx_end` arrives, no new start is allowed.
- R10: When `fifo_en`=0 or `auto_cts_en`=0, `tx_start_ok` is 1 at every character boundary, whatever the level of `cts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Buffered mode enable |
| depth64 | input | 1 | 1 selects 64-entry depth, 0 selects 16 |
| trig_sel | input | 2 | Receive trigger level select |
| auto_rts_en | input | 1 | Automatic RTS enable |
| auto_cts_en | input | 1 | Automatic CTS enable |
| sw_rts | input | 1 | Software RTS request, 1 = asserted |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_push_data | input | 8 | Received character |
| rx_push_err | input | 3 | Error flags: bit0 parity, bit1 framing, bit2 break |
| rx_pop | input | 1 | CPU side removes the head entry |
| rx_pop_data | output | 8 | Head character (show-ahead) |
| rx_pop_err | output | 3 | Head error flags |
| rx_count | output | 7 | Entries held |
| rx_empty | output | 1 | Buffer empty |
| rts_n | output | 1 | Request-to-send, active low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_start | input | 1 | Transmit shifter begins a character |
| tx_end | input | 1 | Transmit shifter finished a character |
| tx_start_ok | output | 1 | A new character may start |

## Verification
The properties assume that the transmit shifter pulses `tx_start` only while `tx_start_ok` is high. They also assume that `tx_end` is pulsed once for each started character, and that configuration inputs change only on clock-synchronous boundaries. The bench drives every input at the falling edge and raises `tx_start` only after observing `tx_start_ok`=1. It sends `tx_end` only after a start it issued itself, and changes depth or mode only with the shifters quiet. `cts_n` is the one input allowed to move freely, since it passes through the synchroniser.

// File: rtl/afc_pkg.sv
package afc_pkg;

    typedef enum logic [1:0] {
        RTS_SOFT = 2'd0,
        RTS_OPEN = 2'd1,
        RTS_HELD = 2'd2
    } rts_state_e;

    typedef enum logic [1:0] {
        TXG_IDLE = 2'd0,
        TXG_BUSY = 2'd1,
        TXG_HOLD = 2'd2
    } txg_state_e;

    // Trigger level for a buffer of the given depth: 1, D/4, D/2, D-D/8.
    function automatic int unsigned trig_level(input int unsigned depth,
                                               input logic [1:0] sel);
        int unsigned lvl;
        unique case (sel)
            2'd0: lvl = 1;
            2'd1: lvl = depth / 4;
            2'd2: lvl = depth / 2;
            default: lvl = depth - depth / 8;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/afc_rx_fifo.sv
module afc_rx_fifo #(
    parameter int DATA_W  = 8,
    parameter int ERR_W   = 3,
    parameter int DEEP    = 64,
    parameter int SHALLOW = 16,
    localparam int WORD_W = DATA_W + ERR_W,
    localparam int PTR_W  = $clog2(DEEP),
    localparam int CNT_W  = $clog2(DEEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fifo_en,
    input  logic              depth64,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);

    logic [WORD_W-1:0] mem [DEEP];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, ptr_mask;
    logic [CNT_W-1:0]  cap;
    logic              do_push, do_pop;

    always_comb begin
        if (!fifo_en)     cap = CNT_W'(1);
        else if (depth64) cap = CNT_W'(DEEP);
        else              cap = CNT_W'(SHALLOW);
        ptr_mask = PTR_W'(cap - CNT_W'(1));
    end

    assign do_pop  = pop && (count != '0) && !flush;
    assign do_push = push && !flush && ((count < cap) || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr + PTR_W'(1)) & ptr_mask;
            if (do_pop)  rd_ptr <= (rd_ptr + PTR_W'(1)) & ptr_mask;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_word = mem[rd_ptr];
    assign empty     = (count == '0);

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
    import afc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    input  logic             empty,
    input  logic             sw_rts,
    output logic             rts_n,
    output rts_state_e       state
);

    rts_state_e next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_SOFT;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            RTS_SOFT: if (auto_en && !flush) next_state = RTS_OPEN;
            RTS_OPEN: begin
                if (!auto_en || flush)  next_state = RTS_SOFT;
                else if (count >= trig) next_state = RTS_HELD;
            end
            RTS_HELD: begin
                if (!auto_en || flush) next_state = RTS_SOFT;
                else if (empty)        next_state = RTS_OPEN;
            end
            default: next_state = RTS_SOFT;
        endcase
    end

    always_comb begin
        unique case (state)
            RTS_OPEN: rts_n = 1'b0;
            RTS_HELD: rts_n = 1'b1;
            default:  rts_n = !sw_rts;
        endcase
    end

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate
    import afc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_en,
    input  logic       cts_n,
    input  logic       tx_start,
    input  logic       tx_end,
    output logic       start_ok,
    output logic       cts_ok,
    output txg_state_e state
);

    logic [SYNC_STAGES-1:0] sync_q;
    txg_state_e next_state;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= !cts_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign cts_ok = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXG_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            TXG_IDLE: begin
                if (gate_en && !cts_ok) next_state = TXG_HOLD;
                else if (tx_start)      next_state = TXG_BUSY;
            end
            TXG_BUSY: if (tx_end) next_state = TXG_IDLE;
            TXG_HOLD: if (!gate_en || cts_ok) next_state = TXG_IDLE;
            default:  next_state = TXG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            TXG_IDLE: start_ok = !gate_en || cts_ok;
            default:  start_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_afc.sv
module uart_afc
    import afc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ERR_W       = 3,
    parameter int DEEP        = 64,
    parameter int SHALLOW     = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              depth64,
    input  logic [1:0]        trig_sel,
    input  logic              auto_rts_en,
    input  logic              auto_cts_en,
    input  logic              sw_rts,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic [ERR_W-1:0]  rx_push_err,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic [ERR_W-1:0]  rx_pop_err,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_empty,
    output logic              rts_n,
    input  logic              cts_n,
    input  logic              tx_start,
    input  logic              tx_end,
    output logic              tx_start_ok
);

    localparam int WORD_W = DATA_W + ERR_W;

    logic              fifo_en_q, depth64_q;
    logic              flush;
    logic [CNT_W-1:0]  trig;
    logic [WORD_W-1:0] head_word;
    logic              cts_ok;
    rts_state_e        rts_st;
    txg_state_e        txg_st;

    // Previous configuration, used only to detect a change.
    always_ff @(posedge clk) begin
        fifo_en_q <= fifo_en;
        depth64_q <= depth64;
    end

    assign flush = (fifo_en != fifo_en_q) || (depth64 != depth64_q);
    assign trig  = depth64 ? CNT_W'(trig_level(DEEP, trig_sel))
                           : CNT_W'(trig_level(SHALLOW, trig_sel));

    afc_rx_fifo #(
        .DATA_W (DATA_W),
        .ERR_W  (ERR_W),
        .DEEP   (DEEP),
        .SHALLOW(SHALLOW)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .fifo_en  (fifo_en),
        .depth64  (depth64),
        .push     (rx_push),
        .push_word({rx_push_err, rx_push_data}),
        .pop      (rx_pop),
        .head_word(head_word),
        .count    (rx_count),
        .empty    (rx_empty)
    );

    assign rx_pop_data = head_word[DATA_W-1:0];
    assign rx_pop_err  = head_word[WORD_W-1:DATA_W];

    afc_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
        .clk    (clk),
        .rst_n  (rst_n),
        .auto_en(fifo_en && auto_rts_en),
        .flush  (flush),
        .count  (rx_count),
        .trig   (trig),
        .empty  (rx_empty),
        .sw_rts (sw_rts),
        .rts_n  (rts_n),
        .state  (rts_st)
    );

    afc_tx_gate #(.SYNC_STAGES(SYNC_STAGES)) u_txg (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (fifo_en && auto_cts_en),
        .cts_n   (cts_n),
        .tx_start(tx_start),
        .tx_end  (tx_end),
        .start_ok(tx_start_ok),
        .cts_ok  (cts_ok),
        .state   (txg_st)
    );

endmodule

// File: rtl/afc_checker.sv
module afc_checker
    import afc_pkg::*;
#(
    parameter int DEEP    = 64,
    parameter int SHALLOW = 16,
    localparam int CNT_W  = $clog2(DEEP + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             depth64,
    input logic [1:0]       trig_sel,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic             sw_rts,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_empty,
    input logic             rts_n,
    input logic             tx_start_ok,
    input logic             tx_end,
    input logic             flush,
    input logic             cts_ok,
    input rts_state_e       rts_st,
    input txg_state_e       txg_st
);

    logic [CNT_W-1:0] cap, trig;
    logic             rts_auto, cts_gate;

    assign cap = !fifo_en ? CNT_W'(1) : (depth64 ? CNT_W'(DEEP) : CNT_W'(SHALLOW));
    assign trig = depth64 ? CNT_W'(trig_level(DEEP, trig_sel))
                          : CNT_W'(trig_level(SHALLOW, trig_sel));
    assign rts_auto = fifo_en && auto_rts_en;
    assign cts_gate = fifo_en && auto_cts_en;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> rx_count <= cap);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rx_push && !rx_pop && rx_count == cap) |=> $stable(rx_count));

    assert_release_at_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_st == RTS_OPEN && rts_auto && !flush && rx_count >= trig) |=> rts_n);

    assert_hold_until_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_st == RTS_HELD && rts_auto && !flush && !rx_empty) |=> rts_n);

    assert_soft_rts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto |=> (rts_n == !sw_rts));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_count == '0));

    assert_cts_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_gate && !cts_ok) |-> !tx_start_ok);

    assert_busy_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (txg_st == TXG_BUSY && !tx_end) |=> !tx_start_ok);

    assert_ungated_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_gate && txg_st == TXG_IDLE) |-> tx_start_ok);

endmodule

bind uart_afc afc_checker #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_afc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .depth64    (depth64),
    .trig_sel   (trig_sel),
    .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en),
    .sw_rts     (sw_rts),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_count   (rx_count),
    .rx_empty   (rx_empty),
    .rts_n      (rts_n),
    .tx_start_ok(tx_start_ok),
    .tx_end     (tx_end),
    .flush      (flush),
    .cts_ok     (cts_ok),
    .rts_st     (rts_st),
    .txg_st     (txg_st)
);

// File: tb/tb_uart_afc.sv
module tb_uart_afc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, depth64 = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       auto_rts_en = 1'b0, auto_cts_en = 1'b0, sw_rts = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic [2:0] rx_push_err = '0;
    logic [7:0] rx_pop_data;
    logic [2:0] rx_pop_err;
    logic [6:0] rx_count;
    logic       rx_empty, rts_n;
    logic       cts_n = 1'b0, tx_start = 1'b0, tx_end = 1'b0, tx_start_ok;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_afc dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .depth64(depth64),
        .trig_sel(trig_sel), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_rts(sw_rts), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .rx_pop_err(rx_pop_err), .rx_count(rx_count), .rx_empty(rx_empty),
        .rts_n(rts_n), .cts_n(cts_n), .tx_start(tx_start), .tx_end(tx_end),
        .tx_start_ok(tx_start_ok)
    );

    task automatic check(input string what, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_push_data = d; rx_push_err = e;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pulse_start();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic pulse_end();
        tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
    endtask

    function automatic int exp_trig(input int depth, input int sel);
        if (sel == 0) return 1;
        if (sel == 1) return depth / 4;
        if (sel == 2) return depth / 2;
        return depth - depth / 8;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 rx_count", rx_count, 0);
        check("R1 rx_empty", rx_empty, 1);
        check("R1 rts_n soft", rts_n, 1);
        check("R1 tx_start_ok", tx_start_ok, 1);

        // R6 software RTS when automatic RTS inactive
        fifo_en = 1'b1; auto_rts_en = 1'b0; sw_rts = 1'b1;
        idle(2);
        check("R6 rts_n sw=1 auto off", rts_n, 0);
        sw_rts = 1'b0;
        idle(1);
        check("R6 rts_n sw=0 auto off", rts_n, 1);
        fifo_en = 1'b0; auto_rts_en = 1'b1; sw_rts = 1'b1;
        idle(2);
        check("R6 rts_n sw=1 fifo off", rts_n, 0);
        auto_rts_en = 1'b0; sw_rts = 1'b0;

        // R8 / R9 automatic CTS
        fifo_en = 1'b1; auto_cts_en = 1'b1; cts_n = 1'b0;
        idle(3);
        check("R8 start ok with cts", tx_start_ok, 1);
        cts_n = 1'b1;
        idle(1);
        check("R8 one edge after cts off", tx_start_ok, 1);
        idle(1);
        check("R8 two edges after cts off", tx_start_ok, 0);
        cts_n = 1'b0;
        idle(2);
        check("R8 two edges after cts on", tx_start_ok, 0);
        idle(1);
        check("R8 three edges after cts on", tx_start_ok, 1);
        pulse_start();
        check("R9 busy blocks start", tx_start_ok, 0);
        cts_n = 1'b1;
        idle(4);
        check("R9 busy with cts off", tx_start_ok, 0);
        cts_n = 1'b0;
        idle(3);
        check("R9 char not ended by cts", tx_start_ok, 0);
        pulse_end();
        check("R9 boundary with cts", tx_start_ok, 1);
        pulse_start();
        cts_n = 1'b1;
        idle(3);
        pulse_end();
        check("R9 stall at boundary", tx_start_ok, 0);
        idle(2);
        check("R9 stall persists", tx_start_ok, 0);
        cts_n = 1'b0;
        idle(3);
        check("R9 resume after stall", tx_start_ok, 1);

        // R10 ungated
        auto_cts_en = 1'b0; cts_n = 1'b1;
        idle(1);
        check("R10 auto cts off", tx_start_ok, 1);
        idle(3);
        check("R10 auto cts off later", tx_start_ok, 1);
        fifo_en = 1'b0; auto_cts_en = 1'b1;
        idle(3);
        check("R10 fifo off", tx_start_ok, 1);
        auto_cts_en = 1'b0; cts_n = 1'b0;

        // Sweep depth and trigger: R2, R3, R4, R5
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 4; s++) begin
                int cap;
                int trg;
                cap = (d != 0) ? 64 : 16;
                trg = exp_trig(cap, s);
                fifo_en = 1'b1; depth64 = d[0]; trig_sel = s[1:0];
                auto_rts_en = 1'b1; sw_rts = 1'b0;
                idle(3);
                check("R4 rts asserted when empty", rts_n, 0);
                for (int k = 1; k <= cap; k++) begin
                    push(8'((k * 29 + d * 7 + s * 3) & 255), 3'(k % 8));
                    idle(1);
                    check($sformatf("R4 rts_n depth=%0d sel=%0d n=%0d", cap, s, k),
                          rts_n, (k >= trg) ? 1 : 0);
                end
                push(8'hA5, 3'd7);
                idle(1);
                check("R3 push into full dropped", rx_count, cap);
                for (int k = 1; k <= cap; k++) begin
                    check($sformatf("R2 data n=%0d", k), rx_pop_data,
                          (k * 29 + d * 7 + s * 3) & 255);
                    check($sformatf("R2 err n=%0d", k), rx_pop_err, k % 8);
                    pop();
                    idle(1);
                    check($sformatf("R5 rts_n left=%0d", cap - k), rts_n,
                          (cap - k > 0) ? 1 : 0);
                end
                pop();
                check("R3 pop from empty", rx_count, 0);
                check("R3 empty flag", rx_empty, 1);
            end
        end

        // R3 single-entry holding register
        fifo_en = 1'b0; auto_rts_en = 1'b0;
        idle(2);
        push(8'h3C, 3'd1);
        push(8'hC3, 3'd6);
        idle(1);
        check("R3 char mode count", rx_count, 1);
        check("R3 char mode keeps first", rx_pop_data, 8'h3C);
        check("R2 char mode err", rx_pop_err, 1);
        pop();
        check("R3 char mode emptied", rx_empty, 1);

        // R7 flush on configuration change
        fifo_en = 1'b1; depth64 = 1'b0; trig_sel = 2'd2; auto_rts_en = 1'b1; sw_rts = 1'b0;
        idle(3);
        for (int k = 0; k < 5; k++) push(8'(k), 3'd0);
        idle(1);
        check("R7 count before flush", rx_count, 5);
        check("R7 rts asserted before flush", rts_n, 0);
        depth64 = 1'b1;
        idle(1);
        check("R7 depth change flush", rx_count, 0);
        check("R7 rts software value", rts_n, 1);
        idle(1);
        check("R7 rts back to automatic", rts_n, 0);
        for (int k = 0; k < 3; k++) push(8'(k), 3'd0);
        fifo_en = 1'b0;
        idle(1);
        check("R7 fifo disable flush", rx_count, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule